// File: doc/BRIEF.md
# Accumulating Step Timer

This block is a timer channel whose count register is not a counter. An 8-bit accumulator is rewritten with the output of an adder each time a selected accumulator clock event occurs. One adder input is either a CPU-programmed step value or the constant all-ones (minus one). The other adder input is normally the accumulator itself. After a reload request, it is a CPU-written shadow value for exactly one accumulation. With these choices, the same datapath can act as a down counter, a counter with a programmable stride, a rate multiplier or a pulse generator.

A programmable prescaler supplies a periodic tick. The tick can clock the accumulator and can shift the step register serially, so the step register can receive asynchronous serial data. The prescaler can be armed for a half-period load on the next falling edge of the serial line, so that later ticks fall near the middle of each bit. A wrap of the adder sets a sticky interrupt flag and drives a dedicated output pin, which either toggles or pulses.

Top module: `acc_step_timer`

## Requirements
- R1: After reset, every readable register, the reload-pending bit, `irq`, `tmr_out` and `ser_out` are zero.
- R2: The accumulator clock is chosen by the 2-bit field at bits 2:1 of config register 2:
  - 0 means every system clock.
  - 1 means the prescaler tick.
  - 2 means a rising edge of `evt_in` after a two-flop synchronizer.
  - 3 means stopped, and the accumulator holds.
- R3: With no reload pending, each accumulator clock sets the accumulator to the sum of itself and the operand, modulo 256.
- R4: If bit 1 of config register 3 is set, the operand is 0xFF and the channel counts down. If it is clear, the operand is the step register.
- R5: Reload requests and the pending bit:
  - The 2-bit field at bits 4:3 of config register 3 picks the reload request source: 0 is a write to address 7, 1 is a wrap, 2 is a synchronized `evt_in` rising edge, 3 is the prescaler tick.
  - A request sets a pending bit (status bit 1). While it is set, the next accumulator clock adds the operand to the shadow value instead of to the accumulator, and then clears the bit.
  - A request with no accumulator clock stays pending.
- R6: A wrap is a carry out when the operand is the step register, or a borrow (no carry) when the operand is minus one. A wrap sets the interrupt flag (status bit 0, driven on `irq`). Writing 1 to status bit 0 clears the flag, and a wrap in the same cycle wins.
- R7: With bit 2 of config register 1 clear, `tmr_out` toggles on every wrap. With it set, `tmr_out` is high for exactly the one cycle after each wrap.
- R8: With prescaler period P (address 5), the prescaler tick occurs once every P+1 system clocks.
- R9: With bit 0 of config register 1 set, each prescaler tick shifts the step register right by one. The synchronized `ser_in` enters at the MSB, and `ser_out` always shows bit 0 of the step register.
- R10: A CPU write to the step register in the same cycle as a serial shift takes effect, and the shift is lost.
- R11: Writing config register 1 with bit 1 set arms the half-load. The next synchronized falling edge of `ser_in` loads the prescaler count with floor(P/2) and disarms it. The next tick then follows floor(P/2)+1 clocks after that load.
- R12: Register map. `cpu_rdata` is combinational from `cpu_addr`, and writes take effect at the clock edge.

| Address | Write | Read |
|---|---|---|
| 0 | shadow value | accumulator |
| 1 | step register | step register |
| 2, 3, 4 | config registers 1, 2 and 3 | config registers 1, 2 and 3 |
| 5 | prescaler period | prescaler period |
| 6 | interrupt clear | status: pending in bit 1, interrupt flag in bit 0 |
| 7 | software reload strobe | zero |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| cpu_we | input | 1 | CPU write enable |
| cpu_addr | input | 3 | CPU register address |
| cpu_wdata | input | W | CPU write data |
| cpu_rdata | output | W | CPU read data for cpu_addr |
| evt_in | input | 1 | External event pin (clock or reload source) |
| ser_in | input | 1 | Serial data input |
| ser_out | output | 1 | Serial data output (step register LSB) |
| tmr_out | output | 1 | Push-pull timer output pin |
| irq | output | 1 | Interrupt flag |

## Verification
The hardest case to reach is the half-load. Its effect is a shift in the phase of a tick that cannot be read from the ports. It also depends on a falling edge that arrives two synchronizer stages late. The stimulus clocks the accumulator from the prescaler while counting down. It then drops `ser_in` at a known edge and reads the accumulator at exact edge offsets: unchanged three edges after the load, decremented on the fourth, then steady for the following full period. Reloads that are left pending without a clock are reached by stopping the accumulator clock, raising the request, and reading the status bit before a single controlled clock.

// File: rtl/acc_timer_pkg.sv
package acc_timer_pkg;

    typedef enum logic [1:0] {
        CLK_SYS = 2'd0,
        CLK_PRE = 2'd1,
        CLK_EXT = 2'd2,
        CLK_OFF = 2'd3
    } acc_clk_sel_e;

    typedef enum logic [1:0] {
        RLD_SW   = 2'd0,
        RLD_WRAP = 2'd1,
        RLD_EXT  = 2'd2,
        RLD_PRE  = 2'd3
    } reload_src_e;

    typedef enum logic [2:0] {
        A_ACC    = 3'd0,
        A_STEP   = 3'd1,
        A_CFG1   = 3'd2,
        A_CFG2   = 3'd3,
        A_CFG3   = 3'd4,
        A_PERIOD = 3'd5,
        A_STATUS = 3'd6,
        A_STROBE = 3'd7
    } reg_addr_e;

    localparam int ADDR_W        = 3;
    localparam int CFG1_SHIFT_EN = 0;
    localparam int CFG1_HALF_ARM = 1;
    localparam int CFG1_PULSE    = 2;
    localparam int CFG2_CLK_LO   = 1;
    localparam int CFG3_NEG_ONE  = 1;
    localparam int CFG3_SRC_LO   = 3;
    localparam int ST_IRQ        = 0;

endpackage

// File: rtl/ats_sync_edge.sv
// Multi-stage input synchronizer; exposes the synchronized level and its
// one-cycle-delayed copy so that the parent can derive either edge.
module ats_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic prev
);
    localparam int LEN = STAGES + 1;

    logic [LEN-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[LEN-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign level = sr_q[STAGES-1];
    assign prev  = sr_q[STAGES];
endmodule

// File: rtl/ats_prescaler.sv
// Down-counting prescaler with one-shot half-period load.
module ats_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] period,
    input  logic         arm_set,
    input  logic         sync_fall,
    output logic         tick
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         arm;
    } pre_t;

    pre_t ps_d, ps_q;

    always_comb begin
        ps_d = ps_q;
        if (ps_q.cnt == '0) ps_d.cnt = period;
        else                ps_d.cnt = ps_q.cnt - 1'b1;
        if (ps_q.arm && sync_fall) begin
            ps_d.cnt = period >> 1;
            ps_d.arm = 1'b0;
        end
        if (arm_set) ps_d.arm = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ps_q <= '0;
        else        ps_q <= ps_d;
    end

    assign tick = (ps_q.cnt == '0);
endmodule

// File: rtl/ats_step_shift.sv
// Step operand register with parallel CPU load and right shift.
module ats_step_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         shift_en,
    input  logic         ser_bit,
    output logic [W-1:0] step,
    output logic         ser_out
);
    logic [W-1:0] step_d, step_q;

    always_comb begin
        step_d = step_q;
        if (wr_en)         step_d = wr_data;
        else if (shift_en) step_d = {ser_bit, step_q[W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= '0;
        else        step_q <= step_d;
    end

    assign step    = step_q;
    assign ser_out = step_q[0];
endmodule

// File: rtl/acc_step_timer.sv
module acc_step_timer
    import acc_timer_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [W-1:0]      cpu_wdata,
    output logic [W-1:0]      cpu_rdata,
    input  logic              evt_in,
    input  logic              ser_in,
    output logic              ser_out,
    output logic              tmr_out,
    output logic              irq
);
    localparam int SUM_W = W + 1;

    typedef struct packed {
        logic [W-1:0] acc;
        logic [W-1:0] shadow;
        logic [W-1:0] cfg1;
        logic [W-1:0] cfg2;
        logic [W-1:0] cfg3;
        logic [W-1:0] period;
        logic         pend;
        logic         irq;
        logic         pin;
    } core_t;

    core_t cq, cd;

    logic         evt_lvl, evt_prev, ser_lvl, ser_prev;
    logic         evt_rise, ser_fall;
    logic         pre_tick;
    logic [W-1:0] step_val;
    logic         step_wr, shift_now, arm_set, sw_strobe;
    logic         acc_tick, wrap_evt, reload_req, minus_one, pulse_mode;
    logic [1:0]   clk_sel_raw;
    logic [W-1:0] operand, base;
    logic [SUM_W-1:0] sum;
    logic [W-1:0] acc_val;
    logic         pend_val;
    reg_addr_e    addr_e;

    ats_sync_edge #(.STAGES(SYNC_STAGES)) u_evt_sync (
        .clk(clk), .rst_n(rst_n), .din(evt_in), .level(evt_lvl), .prev(evt_prev)
    );

    ats_sync_edge #(.STAGES(SYNC_STAGES)) u_ser_sync (
        .clk(clk), .rst_n(rst_n), .din(ser_in), .level(ser_lvl), .prev(ser_prev)
    );

    assign evt_rise = evt_lvl & ~evt_prev;
    assign ser_fall = ~ser_lvl & ser_prev;

    assign addr_e    = reg_addr_e'(cpu_addr);
    assign step_wr   = cpu_we && (addr_e == A_STEP);
    assign sw_strobe = cpu_we && (addr_e == A_STROBE);
    assign arm_set   = cpu_we && (addr_e == A_CFG1) && cpu_wdata[CFG1_HALF_ARM];
    assign shift_now = cq.cfg1[CFG1_SHIFT_EN] && pre_tick;

    ats_prescaler #(.W(W)) u_pre (
        .clk(clk), .rst_n(rst_n), .period(cq.period), .arm_set(arm_set),
        .sync_fall(ser_fall), .tick(pre_tick)
    );

    ats_step_shift #(.W(W)) u_step (
        .clk(clk), .rst_n(rst_n), .wr_en(step_wr), .wr_data(cpu_wdata),
        .shift_en(shift_now), .ser_bit(ser_lvl), .step(step_val), .ser_out(ser_out)
    );

    // Accumulator datapath and control
    always_comb begin
        clk_sel_raw = cq.cfg2[CFG2_CLK_LO +: 2];
        minus_one   = cq.cfg3[CFG3_NEG_ONE];
        pulse_mode  = cq.cfg1[CFG1_PULSE];

        unique case (acc_clk_sel_e'(clk_sel_raw))
            CLK_SYS: acc_tick = 1'b1;
            CLK_PRE: acc_tick = pre_tick;
            CLK_EXT: acc_tick = evt_rise;
            default: acc_tick = 1'b0;
        endcase

        operand  = minus_one ? {W{1'b1}} : step_val;
        base     = cq.pend ? cq.shadow : cq.acc;
        sum      = {1'b0, base} + {1'b0, operand};
        wrap_evt = acc_tick && (sum[W] ^ minus_one);

        unique case (reload_src_e'(cq.cfg3[CFG3_SRC_LO +: 2]))
            RLD_SW:   reload_req = sw_strobe;
            RLD_WRAP: reload_req = wrap_evt;
            RLD_EXT:  reload_req = evt_rise;
            default:  reload_req = pre_tick;
        endcase
    end

    always_comb begin
        cd = cq;
        if (cpu_we) begin
            unique case (addr_e)
                A_ACC:    cd.shadow = cpu_wdata;
                A_CFG1:   cd.cfg1   = cpu_wdata;
                A_CFG2:   cd.cfg2   = cpu_wdata;
                A_CFG3:   cd.cfg3   = cpu_wdata;
                A_PERIOD: cd.period = cpu_wdata;
                A_STATUS: if (cpu_wdata[ST_IRQ]) cd.irq = 1'b0;
                default:  ;
            endcase
        end
        if (acc_tick) cd.acc = sum[W-1:0];
        cd.pend = (cq.pend & ~acc_tick) | reload_req;
        if (wrap_evt) cd.irq = 1'b1;
        cd.pin = pulse_mode ? wrap_evt : (cq.pin ^ wrap_evt);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cq <= '0;
        else        cq <= cd;
    end

    always_comb begin
        unique case (addr_e)
            A_ACC:    cpu_rdata = cq.acc;
            A_STEP:   cpu_rdata = step_val;
            A_CFG1:   cpu_rdata = cq.cfg1;
            A_CFG2:   cpu_rdata = cq.cfg2;
            A_CFG3:   cpu_rdata = cq.cfg3;
            A_PERIOD: cpu_rdata = cq.period;
            A_STATUS: cpu_rdata = {{(W-2){1'b0}}, cq.pend, cq.irq};
            default:  cpu_rdata = '0;
        endcase
    end

    assign acc_val  = cq.acc;
    assign pend_val = cq.pend;
    assign tmr_out  = cq.pin;
    assign irq      = cq.irq;
endmodule

// File: rtl/ats_checker.sv
module ats_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cpu_we,
    input logic [2:0]   cpu_addr,
    input logic [W-1:0] cpu_wdata,
    input logic [W-1:0] acc_val,
    input logic [W-1:0] step_val,
    input logic [1:0]   clk_sel_raw,
    input logic         pend_val,
    input logic         acc_tick,
    input logic         wrap_evt,
    input logic         pulse_mode,
    input logic         irq,
    input logic         tmr_out
);
    assert_hold_when_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel_raw == 2'd3) |=> $stable(acc_val));

    assert_pending_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_val && !acc_tick) |=> pend_val);

    assert_wrap_sets_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |=> irq);

    assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(cpu_we && cpu_addr == 3'd6 && cpu_wdata[0])) |=> irq);

    assert_pulse_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_mode && wrap_evt) |=> tmr_out);

    assert_toggle_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_mode && wrap_evt) |=> (tmr_out != $past(tmr_out)));

    assert_cpu_step_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == 3'd1) |=> (step_val == $past(cpu_wdata)));
endmodule

bind acc_step_timer ats_checker #(.W(W)) u_ats_checker (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .acc_val(acc_val), .step_val(step_val),
    .clk_sel_raw(clk_sel_raw), .pend_val(pend_val), .acc_tick(acc_tick),
    .wrap_evt(wrap_evt), .pulse_mode(pulse_mode), .irq(irq), .tmr_out(tmr_out)
);

// File: tb/acc_step_timer_bench.sv
module acc_step_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_we = 1'b0;
    logic [2:0] cpu_addr = 3'd0;
    logic [7:0] cpu_wdata = 8'd0;
    logic [7:0] cpu_rdata;
    logic       evt_in = 1'b0;
    logic       ser_in = 1'b0;
    logic       ser_out, tmr_out, irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    acc_step_timer u_acc_step_timer (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .evt_in(evt_in),
        .ser_in(ser_in), .ser_out(ser_out), .tmr_out(tmr_out), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        cpu_addr = a;
        #1;
        v = cpu_rdata;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // k+1 accumulator clocks on the system clock, then stop
    task automatic run(input int k);
        wr(3'd3, 8'h00);
        cycles(k);
        wr(3'd3, 8'h06);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], v);
            chk($sformatf("R1 reset reg %0d", a), v, 0);
        end
        chk("R1 reset tmr_out", tmr_out, 0);
        chk("R1 reset irq", irq, 0);
        chk("R1 reset ser_out", ser_out, 0);
    endtask

    task automatic t_sw_reload_add;
        logic [7:0] v;
        wr(3'd3, 8'h06);
        wr(3'd1, 8'd3);
        wr(3'd0, 8'd10);
        wr(3'd7, 8'd0);
        cycles(3);
        rd(3'd6, v); chk("R5 pending without clock", v, 8'h02);
        rd(3'd0, v); chk("R5 acc untouched while pending", v, 0);
        run(0);
        rd(3'd0, v); chk("R5 shadow plus step", v, 13);
        rd(3'd6, v); chk("R5 pending cleared", v, 0);
        run(2);
        rd(3'd0, v); chk("R3 step accumulate", v, 22);
        rd(3'd1, v); chk("R12 step readback", v, 3);
    endtask

    task automatic t_carry;
        logic [7:0] v;
        wr(3'd1, 8'hF0);
        run(0);
        rd(3'd0, v); chk("R3 modulo wrap", v, 6);
        rd(3'd6, v); chk("R6 carry sets irq", v, 1);
        chk("R6 irq pin", irq, 1);
        chk("R7 toggle on carry", tmr_out, 1);
        wr(3'd6, 8'h01);
        chk("R6 irq cleared", irq, 0);
    endtask

    task automatic t_down;
        logic [7:0] v;
        wr(3'd4, 8'h02);
        run(2);
        rd(3'd0, v); chk("R4 down count", v, 3);
        chk("R6 no borrow yet", irq, 0);
        run(3);
        rd(3'd0, v); chk("R4 borrow value", v, 8'hFF);
        chk("R6 borrow sets irq", irq, 1);
        chk("R7 toggle back", tmr_out, 0);
        wr(3'd6, 8'h01);
    endtask

    task automatic t_pulse;
        wr(3'd2, 8'h04);
        wr(3'd0, 8'h00);
        wr(3'd7, 8'h00);
        run(0);
        chk("R7 pulse high", tmr_out, 1);
        cycles(1);
        chk("R7 pulse one cycle", tmr_out, 0);
        wr(3'd6, 8'h01);
        wr(3'd2, 8'h00);
    endtask

    task automatic t_auto_reload;
        logic [7:0] v;
        wr(3'd0, 8'd2);
        wr(3'd7, 8'd0);
        wr(3'd4, 8'h0A);
        run(2);
        rd(3'd0, v); chk("R5 auto wrap value", v, 8'hFF);
        rd(3'd6, v); chk("R5 auto reload pending", v, 3);
        run(0);
        rd(3'd0, v); chk("R5 auto reload applied", v, 1);
        rd(3'd6, v); chk("R5 auto pending consumed", v, 1);
        wr(3'd4, 8'h02);
        wr(3'd6, 8'h01);
    endtask

    task automatic t_prescaler_clock;
        logic [7:0] v;
        wr(3'd5, 8'd3);
        cycles(8);
        wr(3'd3, 8'h02);
        cycles(39);
        wr(3'd3, 8'h06);
        rd(3'd0, v); chk("R8 R2 ten ticks in forty clocks", v, 8'hF7);
        wr(3'd6, 8'h01);
    endtask

    task automatic t_ext_clock;
        logic [7:0] v;
        wr(3'd3, 8'h04);
        for (int i = 0; i < 5; i++) begin
            evt_in = 1'b1; cycles(3);
            evt_in = 1'b0; cycles(3);
        end
        cycles(5);
        wr(3'd3, 8'h06);
        rd(3'd0, v); chk("R2 external edge clock", v, 8'hF2);
    endtask

    task automatic t_ext_reload;
        logic [7:0] v;
        wr(3'd4, 8'h12);
        wr(3'd0, 8'h40);
        evt_in = 1'b1; cycles(3);
        evt_in = 1'b0; cycles(4);
        rd(3'd6, v); chk("R5 pin reload pending", v, 2);
        wr(3'd4, 8'h02);
        run(0);
        rd(3'd0, v); chk("R5 pin reload value", v, 8'h3F);
    endtask

    task automatic t_pre_reload;
        logic [7:0] v;
        wr(3'd0, 8'h80);
        wr(3'd4, 8'h1A);
        cycles(10);
        wr(3'd4, 8'h02);
        rd(3'd6, v); chk("R5 prescaler reload pending", v, 2);
        run(0);
        rd(3'd0, v); chk("R5 prescaler reload value", v, 8'h7F);
    endtask

    task automatic t_serial;
        logic [7:0] v;
        wr(3'd5, 8'd0);
        ser_in = 1'b1;
        wr(3'd1, 8'h81);
        cycles(3);
        chk("R9 ser_out is LSB", ser_out, 1);
        wr(3'd2, 8'h01);
        wr(3'd2, 8'h00);
        rd(3'd1, v); chk("R9 one shift msb in", v, 8'hC0);
        chk("R9 ser_out after shift", ser_out, 0);
        ser_in = 1'b0;
        cycles(4);
        wr(3'd2, 8'h01);
        wr(3'd1, 8'h5A);
        rd(3'd1, v); chk("R10 cpu write beats shift", v, 8'h5A);
        wr(3'd2, 8'h00);
        rd(3'd1, v); chk("R9 shift continues", v, 8'h2D);
    endtask

    task automatic t_half_load;
        logic [7:0] a0, v;
        ser_in = 1'b1;
        wr(3'd5, 8'd7);
        cycles(4);
        wr(3'd2, 8'h02);
        wr(3'd3, 8'h02);
        cycles(2);
        ser_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rd(3'd0, a0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rd(3'd0, v); chk("R11 no tick before half period", v, a0);
        @(posedge clk); @(negedge clk);
        rd(3'd0, v); chk("R11 tick at half period", v, 8'(a0 - 8'd1));
        repeat (7) @(posedge clk);
        @(negedge clk);
        rd(3'd0, v); chk("R11 R8 full period follows", v, 8'(a0 - 8'd1));
        @(posedge clk); @(negedge clk);
        rd(3'd0, v); chk("R11 R8 next tick", v, 8'(a0 - 8'd2));
        wr(3'd3, 8'h06);
    endtask

    initial begin
        cycles(4);
        rst_n = 1'b1;
        cycles(1);
        t_reset();
        t_sw_reload_add();
        t_carry();
        t_down();
        t_pulse();
        t_auto_reload();
        t_prescaler_clock();
        t_ext_clock();
        t_ext_reload();
        t_pre_reload();
        t_serial();
        t_half_load();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #250000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule